// File: doc/BRIEF.md
# Serial Audio Port Controller

This block sits on a simple word-addressed register bus and drives a stereo serial audio link. The link has four wires: a bit clock, a frame (left/right) clock, serial data out and serial data in. Software or a DMA engine writes 32-bit stereo words into a 16-entry transmit queue. It reads captured words from a 16-entry receive queue. Each word carries the left 16-bit sample in its upper half and the right sample in its lower half. Service-request outputs, threshold-based and suitable for a DMA engine, tell the host when either queue needs attention. A maskable interrupt combines these requests with sticky error flags.

The controller either generates the bit clock from its own clock through a programmable divider, or it follows an externally supplied bit clock. The frame clock and serial data are always driven by the block. Each frame is 32 bit clocks long and is sent MSB first in either I2S or MSB-justified framing. An internal loopback path feeds the transmitted bit stream straight into the receiver. Playback and record each have their own disable bit. A single link-enable bit starts the link, but the link runs only while at least one direction is enabled.

Register select (`bus_addr_i`): 0 global control, 1 serial control, 2 status (read only), 3 interrupt mask, 4 flag clear (write only, reads 0), 5 clock divider, 6 data port.

Top module: `saudio_ctrl`

## Requirements
- R1: After reset, global control reads 0, serial control reads 0x18 (both directions disabled), interrupt mask reads 0, clock divider reads 0x0C and status reads 0x89.
- R2: A write to the data port pushes one word into the transmit queue (16 entries), and a write while it is full is ignored. A read of the data port pops one word from the receive queue. A read while that queue is empty returns 0 and changes nothing.
- R3: Status bit 0 = transmit queue not full, bit 1 = receive queue not empty, bit 2 = link running, bit 7 = link off.
- R4: Transmit request (status bit 3, `tx_req_o`) is high while the transmit level is at or below global control bits 11:8. Receive request (status bit 4, `rx_req_o`) is high while the receive level is at or above global control bits 15:12, with a threshold of 0 treated as 1.
- R5: The link runs only while global control bit 0 is 1 and not both serial control bit 3 (record disable) and bit 4 (playback disable) are 1.
- R6: A frame is 32 bit-clock periods with the left sample first, MSB first, and data changes on the falling bit-clock edge. With serial control bit 0 = 1 (MSB-justified), the frame clock is high for the left half and the MSB is on the first rising edge of the half. With bit 0 = 0 (I2S), the frame clock is low for the left half and every bit lags one bit clock, so the first bit of a frame is the previous word's LSB.
- R7: With global control bit 2 = 1 the block drives the bit clock (`bclk_oe_o` = 1). The bit clock toggles every divider-value clock cycles (0 acts as 1) and idles high when the link is off. With bit 2 = 0 the link is timed by `bclk_i`.
- R8: If playback is enabled and the transmit queue is empty when a new word is due, a zero word is sent and status bit 5 is set. It stays set until 1 is written to bit 5 of the clear register.
- R9: If record is enabled and the receive queue is full when a word completes, the word is discarded and status bit 6 is set. It stays set until 1 is written to bit 6 of the clear register.
- R10: `irq_o` is high when any of status bits 3 to 6 is high and the same bit of the interrupt mask is 1.
- R11: With serial control bit 5 = 1 the receiver samples the block's own serial output instead of `sdata_i`.
- R12: While global control bit 3 is 1, both queues are emptied, both sticky flags are cleared and the link is held off.
- R13: With playback disabled the transmit queue is not drained and zero words are sent without an underrun. With record disabled no word enters the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Masked interrupt |
| tx_req_o | output | 1 | Transmit service request |
| rx_req_o | output | 1 | Receive service request |
| bclk_i | input | 1 | External bit clock |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe_o | output | 1 | Bit clock driven by the block |
| lrclk_o | output | 1 | Frame clock |
| sdata_i | input | 1 | Serial data in |
| sdata_o | output | 1 | Serial data out |

## Verification
The assertions check the following on every cycle:
- the queue level never passes its depth, and a full queue stays full under a lone push;
- the sticky error flags clear only by a write-one clear or a flush;
- a flush leaves both queues empty;
- an idle link moves no words;
- the frame clock moves only on a falling bit-clock tick;
- the generated clock idles high;
- an empty-queue read returns zero.

The exact bit order and frame-clock polarity of both framings, the one-bit I2S lag and the divider period can only be shown by the bench scenarios. The same holds for the loopback round trip, slave-clock operation, the ignored seventeenth write, threshold crossings and the per-direction gating.

// File: rtl/saudio_pkg.sv
package saudio_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_SER  = 3'd1,
    REG_STAT = 3'd2,
    REG_MASK = 3'd3,
    REG_CLR  = 3'd4,
    REG_DIV  = 3'd5,
    REG_DATA = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic off;
    logic ror;
    logic tur;
    logic rfs;
    logic tfs;
    logic busy;
    logic rx_ne;
    logic tx_nf;
  } status_t;
endpackage

// File: rtl/saudio_fifo.sv
module saudio_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] level_q;
  logic          push_ok, pop_ok;

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; level_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0; rd_q <= '0; level_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  a_r2_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/saudio_bclk.sv
module saudio_bclk #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bclk_i,
  output logic             bclk_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q, div_eff;
  logic             bclk_q, wrap;
  logic [2:0]       sync_q;
  logic             ext_rise, ext_fall;

  assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
  assign wrap     = (cnt_q == div_eff - DIV_W'(1));
  assign ext_rise = sync_q[1] && !sync_q[2];
  assign ext_fall = !sync_q[1] && sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; bclk_q <= 1'b1; sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], bclk_i};
      if (!run_i || !master_i) begin
        cnt_q <= '0; bclk_q <= 1'b1;
      end else if (wrap) begin
        cnt_q <= '0; bclk_q <= !bclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fall_o = run_i && (master_i ? (wrap && bclk_q)  : ext_fall);
  assign rise_o = run_i && (master_i ? (wrap && !bclk_q) : ext_rise);
  assign bclk_o = bclk_q;

  a_r7_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> bclk_o);
endmodule

// File: rtl/saudio_link.sv
module saudio_link #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         mj_i,
  input  logic         loop_i,
  input  logic         play_i,
  input  logic         rec_i,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic [W-1:0] tx_word_i,
  input  logic         tx_empty_i,
  input  logic         rx_full_i,
  input  logic         sdata_i,
  output logic         tx_pop_o,
  output logic         rx_push_o,
  output logic [W-1:0] rx_word_o,
  output logic         urun_o,
  output logic         orun_o,
  output logic         sdata_o,
  output logic         lrclk_o
);
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  tx_sh_q, rx_sh_q;
  logic          started_q, pend_q, dly_q;
  logic          last, load, rx_bit, word_done;

  assign last     = (cnt_q == CW'(W-1));
  assign load     = fall_i && last;
  assign tx_pop_o = load && play_i && !tx_empty_i;
  assign urun_o   = load && play_i && tx_empty_i;

  // I2S output is the MSB-justified stream delayed by one bit clock
  assign sdata_o  = mj_i ? tx_sh_q[W-1] : dly_q;
  assign lrclk_o  = mj_i ? !cnt_q[CW-1] : cnt_q[CW-1];

  assign rx_bit    = loop_i ? sdata_o : sdata_i;
  assign word_done = rise_i && started_q && (mj_i ? last : (cnt_q == '0 && pend_q));
  assign rx_word_o = {rx_sh_q[W-2:0], rx_bit};
  assign rx_push_o = word_done && rec_i && !rx_full_i;
  assign orun_o    = word_done && rec_i && rx_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1; tx_sh_q <= '0; rx_sh_q <= '0;
      started_q <= 1'b0; pend_q <= 1'b0; dly_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '1; tx_sh_q <= '0; rx_sh_q <= '0;
      started_q <= 1'b0; pend_q <= 1'b0; dly_q <= 1'b0;
    end else begin
      if (fall_i) begin
        cnt_q     <= cnt_q + 1'b1;
        dly_q     <= tx_sh_q[W-1];
        started_q <= 1'b1;
        if (load) tx_sh_q <= tx_pop_o ? tx_word_i : '0;
        else      tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
      end
      if (rise_i && started_q) begin
        rx_sh_q <= {rx_sh_q[W-2:0], rx_bit};
        if (last) pend_q <= 1'b1;
      end
    end
  end

  a_r6_lrclk_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !clear_i) |=> ($stable(lrclk_o) || !$stable(mj_i)));
endmodule

// File: rtl/saudio_ctrl.sv
module saudio_ctrl
  import saudio_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned TH_W    = 4,
  parameter int unsigned DIV_RST = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o,
  output logic             tx_req_o,
  output logic             rx_req_o,
  input  logic             bclk_i,
  output logic             bclk_o,
  output logic             bclk_oe_o,
  output logic             lrclk_o,
  input  logic             sdata_i,
  output logic             sdata_o
);
  localparam int unsigned LW = $clog2(DEPTH) + 1;

  logic             en_q, drv_q, flush_q, mj_q, norec_q, noplay_q, loop_q;
  logic [TH_W-1:0]  tfth_q, rfth_q;
  logic [3:0]       mask_q;
  logic [DIV_W-1:0] div_q;
  logic             tur_q, ror_q;

  logic             wr, rd, clr_wr, active;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [BUS_W-1:0] tx_head, rx_head, rx_word;
  logic [LW-1:0]    tx_level, rx_level, rth_eff;
  logic             fall, rise, urun, orun;
  status_t          stat;

  assign wr      = bus_sel_i && bus_we_i;
  assign rd      = bus_sel_i && !bus_we_i;
  assign clr_wr  = wr && (bus_addr_i == REG_CLR);
  assign tx_push = wr && (bus_addr_i == REG_DATA);
  assign rx_pop  = rd && (bus_addr_i == REG_DATA);
  assign active  = en_q && !(norec_q && noplay_q) && !flush_q;
  assign rth_eff = (rfth_q == '0) ? LW'(1) : LW'(rfth_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; drv_q <= 1'b0; flush_q <= 1'b0; tfth_q <= '0; rfth_q <= '0;
      mj_q <= 1'b0; norec_q <= 1'b1; noplay_q <= 1'b1; loop_q <= 1'b0;
      mask_q <= '0; div_q <= DIV_W'(DIV_RST);
    end else if (wr) begin
      case (bus_addr_i)
        REG_CTRL: begin
          en_q <= bus_wdata_i[0]; drv_q <= bus_wdata_i[2]; flush_q <= bus_wdata_i[3];
          tfth_q <= bus_wdata_i[8 +: TH_W]; rfth_q <= bus_wdata_i[12 +: TH_W];
        end
        REG_SER: begin
          mj_q <= bus_wdata_i[0]; norec_q <= bus_wdata_i[3];
          noplay_q <= bus_wdata_i[4]; loop_q <= bus_wdata_i[5];
        end
        REG_MASK: mask_q <= bus_wdata_i[6:3];
        REG_DIV:  div_q  <= bus_wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // sticky flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tur_q <= 1'b0; ror_q <= 1'b0;
    end else if (flush_q) begin
      tur_q <= 1'b0; ror_q <= 1'b0;
    end else begin
      if (urun) tur_q <= 1'b1;
      else if (clr_wr && bus_wdata_i[5]) tur_q <= 1'b0;
      if (orun) ror_q <= 1'b1;
      else if (clr_wr && bus_wdata_i[6]) ror_q <= 1'b0;
    end
  end

  saudio_fifo #(.W(BUS_W), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush_q), .push_i(tx_push), .wdata_i(bus_wdata_i),
    .pop_i(tx_pop), .rdata_o(tx_head), .level_o(tx_level), .full_o(tx_full),
    .empty_o(tx_empty));

  saudio_fifo #(.W(BUS_W), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush_q), .push_i(rx_push), .wdata_i(rx_word),
    .pop_i(rx_pop), .rdata_o(rx_head), .level_o(rx_level), .full_o(rx_full),
    .empty_o(rx_empty));

  saudio_bclk #(.DIV_W(DIV_W)) i_bclk (
    .clk_i, .rst_ni, .run_i(active), .master_i(drv_q), .div_i(div_q),
    .bclk_i, .bclk_o, .fall_o(fall), .rise_o(rise));

  saudio_link #(.W(BUS_W)) i_link (
    .clk_i, .rst_ni, .clear_i(!active), .mj_i(mj_q), .loop_i(loop_q),
    .play_i(!noplay_q), .rec_i(!norec_q), .fall_i(fall), .rise_i(rise),
    .tx_word_i(tx_head), .tx_empty_i(tx_empty), .rx_full_i(rx_full),
    .sdata_i, .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_word_o(rx_word),
    .urun_o(urun), .orun_o(orun), .sdata_o, .lrclk_o);

  always_comb begin
    stat.off   = !active;
    stat.ror   = ror_q;
    stat.tur   = tur_q;
    stat.rfs   = (rx_level >= rth_eff);
    stat.tfs   = (tx_level <= LW'(tfth_q));
    stat.busy  = active;
    stat.rx_ne = !rx_empty;
    stat.tx_nf = !tx_full;
  end

  assign tx_req_o  = stat.tfs;
  assign rx_req_o  = stat.rfs;
  assign irq_o     = |(stat[6:3] & mask_q);
  assign bclk_oe_o = drv_q;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_CTRL: bus_rdata_o = BUS_W'({rfth_q, tfth_q, 4'b0, flush_q, drv_q, 1'b0, en_q});
      REG_SER:  bus_rdata_o = BUS_W'({loop_q, noplay_q, norec_q, 2'b0, mj_q});
      REG_STAT: bus_rdata_o = BUS_W'(stat);
      REG_MASK: bus_rdata_o = BUS_W'({mask_q, 3'b0});
      REG_DIV:  bus_rdata_o = BUS_W'(div_q);
      REG_DATA: bus_rdata_o = rx_empty ? '0 : rx_head;
      default:  bus_rdata_o = '0;
    endcase
  end

  a_r8_tur_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tur_q && !flush_q && !(clr_wr && bus_wdata_i[5])) |=> tur_q);
  a_r9_ror_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ror_q && !flush_q && !(clr_wr && bus_wdata_i[6])) |=> ror_q);
  a_r12_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |=> (tx_empty && rx_empty));
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !(tx_pop || rx_push));
  a_r2_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && rx_empty) |-> (bus_rdata_o == '0));
endmodule

// File: tb/test_saudio_ctrl.sv
module test_saudio_ctrl;
  localparam int CLK_P = 10;

  logic clk = 0, rst_ni = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, tx_req, rx_req, bclk_in = 1, bclk_out, bclk_oe, lrclk, sd_in = 0, sd_out;

  int checks = 0, failures = 0;
  bit done = 0;

  logic cap_on = 0, bclk_prev = 1;
  int nr = 0, cyc = 0;
  logic lr_cap [70];
  logic sd_cap [70];
  int t_cap [70];

  always #(CLK_P/2) clk = ~clk;

  saudio_ctrl i_saudio_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .tx_req_o(tx_req), .rx_req_o(rx_req), .bclk_i(bclk_in),
    .bclk_o(bclk_out), .bclk_oe_o(bclk_oe), .lrclk_o(lrclk), .sdata_i(sd_in),
    .sdata_o(sd_out));

  always @(negedge clk) begin
    cyc++;
    if (!cap_on) nr = 0;
    else if (!bclk_prev && bclk_out) begin
      if (nr < 70) begin lr_cap[nr] = lrclk; sd_cap[nr] = sd_out; t_cap[nr] = cyc; end
      nr++;
    end
    bclk_prev = bclk_out;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic flush_all();
    wr(0, 32'h8); wr(0, 32'h0); wr(4, 32'h60);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1 ctrl reset", d, 0);
    rd(1, d); chk("R1 serial reset", d, 32'h18);
    rd(2, d); chk("R1 R3 status reset", d, 32'h89);
    rd(3, d); chk("R1 mask reset", d, 0);
    rd(5, d); chk("R1 divider reset", d, 32'h0C);
    chk("R10 irq at reset", irq, 0);
    chk("R4 tx_req at reset", tx_req, 1);
    chk("R4 rx_req at reset", rx_req, 0);
    chk("R7 bclk idle high", bclk_out, 1);
    chk("R7 bclk not driven", bclk_oe, 0);
  endtask

  // fill tx, overfill, play through loopback into rx until overrun
  task automatic t_queue();
    logic [31:0] d;
    int g;
    wr(0, 32'hF200);
    for (int i = 0; i < 2; i++) wr(6, 32'h1000_0000 + i);
    chk("R4 tx_req at threshold", tx_req, 1);
    wr(6, 32'h1000_0002);
    chk("R4 tx_req above threshold", tx_req, 0);
    for (int i = 3; i < 16; i++) wr(6, 32'h1000_0000 + i);
    rd(2, d); chk("R3 status tx full", d, 32'h80);
    wr(6, 32'hDEAD_0017);
    wr(5, 32'h1);
    wr(1, 32'h21);
    wr(0, 32'hF205);
    rd(2, d); chk("R3 busy while running", d[7:2], 6'b000001);
    g = 0;
    do begin rd(2, d); g++; end while (!d[6] && g < 4000);
    wr(1, 32'h18);
    chk("R9 overrun flag set", d[6], 1);
    chk("R8 underrun flag set", d[5], 1);
    chk("R4 rx_req at level 16 thr 15", rx_req, 1);
    for (int i = 0; i < 16; i++) begin
      rd(6, d); chk("R2 R11 loopback word order", d, 32'h1000_0000 + i);
      if (i == 1) chk("R4 rx_req below threshold", rx_req, 0);
    end
    rd(6, d); chk("R2 empty read zero", d, 0);
    rd(2, d); chk("R2 empty read leaves rx empty", d[1], 0);
    wr(0, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    chk("R10 irq masked off", irq, 0);
    wr(3, 32'h20); chk("R10 irq on underrun", irq, 1);
    wr(4, 32'h20); chk("R8 irq after tur clear", irq, 0);
    rd(2, d);      chk("R8 tur cleared", d[6:5], 2'b10);
    wr(3, 32'h40); chk("R10 irq on overrun", irq, 1);
    wr(4, 32'h40); chk("R9 irq after ror clear", irq, 0);
    rd(2, d);      chk("R9 ror cleared", d[6:5], 2'b00);
    wr(3, 32'h08); chk("R10 irq on tx request", irq, 1);
    wr(3, 32'h00);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) wr(6, 32'h5555_0000 + i);
    wr(0, 32'h8);
    rd(2, d); chk("R12 link held off by flush", d[7], 1);
    wr(0, 32'h0);
    rd(2, d); chk("R12 status after flush", d, 32'h89);
    rd(6, d); chk("R12 tx not looped rx empty", d, 0);
  endtask

  task automatic t_frame(bit mj);
    logic [31:0] wa = mj ? 32'hA5C3_0F96 : 32'h3C5A_F00F;
    logic [31:0] wb = mj ? 32'h8001_7FFE : 32'hC001_2345;
    logic mjbit [64];
    logic [31:0] d;
    int g, bad_lr, bad_sd;
    string tag = mj ? "MJ" : "I2S";
    flush_all();
    wr(5, 32'h3);
    wr(6, wa); wr(6, wb);
    wr(1, mj ? 32'h21 : 32'h20);
    @(posedge clk); cap_on = 1;
    wr(0, 32'h5);
    chk("R7 bclk driven", bclk_oe, 1);
    g = 0;
    while (nr < 66 && g < 5000) begin @(posedge clk); g++; end
    cap_on = 0;
    wr(1, 32'h18); wr(0, 32'h0);
    bad_lr = 0; bad_sd = 0;
    for (int r = 0; r < 64; r++) begin
      logic [31:0] w;
      w = (r < 32) ? wa : wb;
      mjbit[r] = w[31 - (r % 32)];
    end
    for (int r = 0; r < 64; r++) begin
      logic elr, esd;
      elr = mj ? ((r % 32) < 16) : ((r % 32) >= 16);
      esd = mj ? mjbit[r] : ((r == 0) ? 1'b0 : mjbit[r-1]);
      if (lr_cap[r] !== elr) bad_lr++;
      if (sd_cap[r] !== esd) bad_sd++;
    end
    chk({"R6 frame clock ", tag}, bad_lr, 0);
    chk({"R6 data bits ", tag}, bad_sd, 0);
    chk("R7 bit clock period", t_cap[1] - t_cap[0], 6);
    rd(6, d); chk({"R11 loopback first ", tag}, d, wa);
    rd(6, d); chk({"R11 loopback second ", tag}, d, wb);
    flush_all();
  endtask

  task automatic t_slave();
    logic [31:0] d;
    flush_all();
    wr(6, 32'h6B2D_94E1);
    wr(1, 32'h21);
    wr(0, 32'h1);
    chk("R7 slave bclk not driven", bclk_oe, 0);
    for (int i = 0; i < 40; i++) begin
      repeat (8) @(negedge clk); bclk_in = 0;
      repeat (8) @(negedge clk); bclk_in = 1;
    end
    wr(1, 32'h18); wr(0, 32'h0);
    rd(6, d); chk("R7 slave clock round trip", d, 32'h6B2D_94E1);
    flush_all();
  endtask

  task automatic t_gate();
    logic [31:0] d;
    flush_all();
    wr(5, 32'h1);
    wr(0, 32'h1);
    rd(2, d); chk("R5 enabled but both directions off", d[7], 1);
    wr(0, 32'h0);
    wr(1, 32'h31);
    wr(6, 32'h7777_1111);
    wr(0, 32'h5);
    rd(2, d); chk("R5 record only runs", {d[7], d[2]}, 2'b01);
    wait_clk(300);
    chk("R13 tx not drained with playback off", tx_req, 0);
    rd(2, d); chk("R13 no underrun with playback off", {d[5], d[1]}, 2'b01);
    rd(6, d); chk("R13 zero words sent", d, 0);
    wr(1, 32'h39);
    rd(2, d); chk("R5 both disabled stops link", {d[7], d[2]}, 2'b10);
    wr(0, 32'h0);
    flush_all();
    wr(1, 32'h29);
    wr(6, 32'h7777_2222);
    wr(0, 32'h5);
    wait_clk(300);
    rd(2, d); chk("R13 rx empty with record off", d[1], 0);
    chk("R13 tx drained with playback on", tx_req, 1);
    wr(1, 32'h18); wr(0, 32'h0);
    flush_all();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    t_reset();
    t_queue();
    t_irq();
    t_flush();
    t_frame(1'b1);
    t_frame(1'b0);
    t_slave();
    t_gate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule